// File: doc/BRIEF.md
# GPIO Pin Interrupt Trigger Detector

This block watches the eight synchronized input levels of a general-purpose I/O port and turns pin activity into interrupt flags. Each pin has its own trigger setting, built from three bit registers. A sense bit chooses level or edge detection. A polarity bit chooses high or low level, or rising or falling edge. A dual-edge bit, which counts only in edge mode, makes the pin fire on every transition. To find edges, the block compares each pin with a registered copy of its value from the previous clock.

When a trigger condition holds, the block latches it into a raw flag. The flag stays set until software writes a one to the matching bit of a clear register. A mask register gates the raw flags into a masked status. The OR of all masked bits drives a single interrupt request. Software reaches every register through a simple register bus: a write strobe, a 3-bit address and write data, with read data returned combinationally for the address on the bus.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is 0.
- R2: A pin with sense bit 1 is in level mode. With polarity bit 1 its raw flag sets on each clock edge at which the pin is high. With polarity bit 0 it sets on each clock edge at which the pin is low.
- R3: A pin with sense bit 0 and dual-edge bit 0 is in edge mode. Its flag sets at the clock edge where the pin differs from its value at the previous clock edge. The transition must be 0 to 1 when the polarity bit is 1, and 1 to 0 when the polarity bit is 0. No flag sets while the pin is steady.
- R4: In edge mode with dual-edge bit 1, every transition sets the flag, whatever the polarity bit holds.
- R5: In level mode the dual-edge bit has no effect.
- R6: A raw flag stays set after its trigger goes away. Writing the clear register (address 6) clears exactly the flags whose write-data bits are 1. Zero bits leave flags unchanged.
- R7: When a trigger occurs in the same cycle as a clear of that pin, the flag stays set. A level trigger that persists therefore survives a clear.
- R8: The masked status (address 5) reads raw AND mask. `irq_o` is the OR of the masked status. The mask (address 3) does not alter the raw flags.
- R9: The register map is: address 0 sense, 1 dual-edge, 2 polarity, 3 mask (all read/write); 4 raw flags and 5 masked status (read-only, writes ignored); 6 clear (write-only, reads 0). Bit n of each register belongs to pin n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 8 | Synchronized pin levels |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is a trigger that coincides with a clear of the same pin. The bench creates it by holding a level trigger active while it writes the clear register, so the set and the clear land in one cycle. The bench also has to separate the edge history from the flags left by reconfiguration. It does this by holding each vector's starting levels through the configuration writes, then clearing all flags, then applying the second level. The expected flag is therefore a pure function of the two levels and the three configuration bits.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_SENSE    = 3'd0,
    REG_BOTH     = 3'd1,
    REG_POL      = 3'd2,
    REG_MASK     = 3'd3,
    REG_RAW      = 3'd4,
    REG_MSK_STAT = 3'd5,
    REG_CLEAR    = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  output logic [N-1:0]      sense_o,
  output logic [N-1:0]      both_o,
  output logic [N-1:0]      pol_o,
  output logic [N-1:0]      mask_o,
  output logic [N-1:0]      clr_o
);
  logic [N-1:0] sense_q, both_q, pol_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      mask_q  <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        REG_SENSE: sense_q <= wdata_i;
        REG_BOTH:  both_q  <= wdata_i;
        REG_POL:   pol_q   <= wdata_i;
        REG_MASK:  mask_q  <= wdata_i;
        default:   ;
      endcase
    end
  end

  assign sense_o = sense_q;
  assign both_o  = both_q;
  assign pol_o   = pol_q;
  assign mask_o  = mask_q;
  // one-cycle clear pulse, only for the clear address
  assign clr_o   = (wr_en_i && addr_i == REG_CLEAR) ? wdata_i : '0;

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(sense_q) && $stable(both_q) && $stable(pol_q) && $stable(mask_q)); // R9
  AST_CLR_ONLY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |-> clr_o == '0); // R6
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic sense_i,
  input  logic both_i,
  input  logic pol_i,
  input  logic clr_i,
  output logic raw_o
);
  logic prev_q, raw_q, rise, fall, hit;

  always_comb begin
    rise = pin_i & ~prev_q;
    fall = ~pin_i & prev_q;
    if (sense_i)     hit = pol_i ? pin_i : ~pin_i;
    else if (both_i) hit = rise | fall;
    else             hit = pol_i ? rise : fall;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      raw_q  <= 1'b0;
    end else begin
      prev_q <= pin_i;
      raw_q  <= (raw_q & ~clr_i) | hit; // set beats clear
    end
  end

  assign raw_o = raw_q;

  AST_LEVEL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sense_i && pol_i && pin_i |=> raw_o); // R2
  AST_LEVEL_IGNORES_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sense_i && both_i && !pol_i && !pin_i |=> raw_o); // R5
  AST_EDGE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !raw_o && !sense_i && (pin_i == prev_q) |=> !raw_o); // R3
  AST_DUAL_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sense_i && both_i && (pin_i != prev_q) |=> raw_o); // R4
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_o && !clr_i |=> raw_o); // R6
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      pin_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  output logic [N-1:0]      rdata_o,
  output logic              irq_o
);
  logic [N-1:0] sense, both, pol, mask, clr, raw, masked;

  gpio_irq_cfg #(.N(N)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .sense_o (sense),
    .both_o  (both),
    .pol_o   (pol),
    .mask_o  (mask),
    .clr_o   (clr)
  );

  for (genvar i = 0; i < N; i++) begin : g_pin
    gpio_irq_pin u_pin (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pin_i   (pin_i[i]),
      .sense_i (sense[i]),
      .both_i  (both[i]),
      .pol_i   (pol[i]),
      .clr_i   (clr[i]),
      .raw_o   (raw[i])
    );
  end

  assign masked = raw & mask;
  assign irq_o  = |masked;

  always_comb begin
    case (addr_i)
      REG_SENSE:    rdata_o = sense;
      REG_BOTH:     rdata_o = both;
      REG_POL:      rdata_o = pol;
      REG_MASK:     rdata_o = mask;
      REG_RAW:      rdata_o = raw;
      REG_MSK_STAT: rdata_o = masked;
      default:      rdata_o = '0;
    endcase
  end

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask != '0)); // R8
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (raw != '0)); // R8
endmodule

// File: tb/gpio_irq_detect_bench.sv
module gpio_irq_detect_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin = '0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_detect u_gpio_irq_detect (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // {sense, dual-edge, polarity, level before, level after}
  localparam logic [39:0] VEC [6] = '{
    {8'h00, 8'h00, 8'hFF, 8'h00, 8'h0F},  // R3 rising
    {8'h00, 8'h00, 8'h00, 8'hFF, 8'hF0},  // R3 falling
    {8'h00, 8'hFF, 8'h55, 8'h0F, 8'h3C},  // R4 dual edge
    {8'hFF, 8'h00, 8'hF0, 8'h00, 8'h00},  // R2 level
    {8'hFF, 8'hFF, 8'h0F, 8'hFF, 8'hFF},  // R5 level ignores dual edge
    {8'hA5, 8'h3C, 8'h96, 8'h5A, 8'hC3}   // R2 R3 R4 R5 mixed
  };

  function automatic logic [7:0] exp_raw(input logic [7:0] s, b, e, bf, af);
    logic [7:0] lvl, rise, fall, edg;
    lvl  = (e & (bf | af)) | (~e & (~bf | ~af));
    rise = af & ~bf;
    fall = bf & ~af;
    edg  = (b & (rise | fall)) | (~b & ((e & rise) | (~e & fall)));
    return (s & lvl) | (~s & edg);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, e;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), d);
      chk($sformatf("R1 reg %0d after reset", a), d, 8'h00);
    end
    chk("R1 irq after reset", {7'b0, irq}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // vector walk
    for (int v = 0; v < 6; v++) begin
      logic [7:0] s, b, p, bf, af;
      {s, b, p, bf, af} = VEC[v];
      pin = bf;
      wr(3'd0, s); wr(3'd1, b); wr(3'd2, p); wr(3'd3, 8'hFF);
      wr(3'd6, 8'hFF);
      pin = af;
      @(negedge clk);
      @(negedge clk);
      e = exp_raw(s, b, p, bf, af);
      rd(3'd4, d);
      chk($sformatf("R2/R3/R4/R5 vector %0d raw", v), d, e);
      chk($sformatf("R8 vector %0d irq", v), {7'b0, irq}, {7'b0, |e});
    end

    // R6 hold and selective clear
    pin = 8'h00;
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    wr(3'd6, 8'hFF);
    pin = 8'h01; @(negedge clk);
    pin = 8'h00; @(negedge clk); @(negedge clk);
    rd(3'd4, d); chk("R6 flag held after pulse", d, 8'h01);
    wr(3'd6, 8'h00); rd(3'd4, d); chk("R6 zero clear no effect", d, 8'h01);
    wr(3'd6, 8'hFE); rd(3'd4, d); chk("R6 other-bit clear no effect", d, 8'h01);
    wr(3'd6, 8'h01); rd(3'd4, d); chk("R6 clear removes flag", d, 8'h00);

    // R8 masking
    pin = 8'h01; @(negedge clk); pin = 8'h00; @(negedge clk);
    wr(3'd3, 8'h00);
    rd(3'd5, d); chk("R8 masked status with mask 0", d, 8'h00);
    chk("R8 irq with mask 0", {7'b0, irq}, 8'h00);
    rd(3'd4, d); chk("R8 raw kept under mask 0", d, 8'h01);
    wr(3'd3, 8'h01);
    rd(3'd5, d); chk("R8 masked status with mask 1", d, 8'h01);
    chk("R8 irq with mask 1", {7'b0, irq}, 8'h01);

    // R9 read-only and write-only addresses, readback
    wr(3'd4, 8'hFF); rd(3'd4, d); chk("R9 write to raw ignored", d, 8'h01);
    wr(3'd5, 8'hFF); rd(3'd4, d); chk("R9 write to masked ignored", d, 8'h01);
    rd(3'd6, d); chk("R9 clear reads zero", d, 8'h00);
    wr(3'd3, 8'h5A); rd(3'd3, d); chk("R9 mask readback", d, 8'h5A);

    // R7 persistent level survives clear
    wr(3'd3, 8'hFF);
    pin = 8'h02;
    wr(3'd2, 8'h02); wr(3'd0, 8'h02);
    wr(3'd6, 8'hFF);
    rd(3'd4, d); chk("R7 level flag survives clear", d, 8'h02);
    pin = 8'h00; @(negedge clk);
    wr(3'd6, 8'hFF);
    rd(3'd4, d); chk("R7 flag clears once level gone", d, 8'h00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule